// File: doc/BRIEF.md
# First-Level Compressed Prefix Lookup Stage

This block resolves the top sixteen bits of an IPv4 destination address against a compressed first-level forwarding structure. The structure is split across four on-chip tables: a codeword table selected by the top twelve address bits, a base table shared by each run of four codewords, a table of precomputed 4-bit offsets with one row per allowed bitmask shape, and a pointer table. A lookup slices fields out of the address, reads the tables in a fixed order and adds three small numbers to find a pointer. The result is either a next-hop index or the index of a second-level chunk.

Software fills every table through one write port while no lookup is in flight. Lookups then stream in, one per cycle, under a valid/ready handshake. Each result leaves three cycles after its address, in arrival order. The low sixteen address bits travel alongside the result so that a later chunk search can use them. A codeword that marks a sparse or empty bitmask carries its next hop inline, and the offset and pointer tables then play no part in the result.

Top module: `prefix_l1_lookup`

## Requirements
- R1: After reset `out_valid` is 0 and `in_ready` is 1.
- R2: A codeword is 16 bits: row field in [15:6] and offset field in [5:0]. When the row field's top four bits are all ones, the result is a next hop with `out_root` 0 and `out_index` = {2'b00, row[5:0], offset}, whatever the other tables hold.
- R3: Otherwise the pointer index is base[addr[31:22]] + offset + offset_table[row][addr[19:16]]. A pointer entry holds a type in [15:14] and a value in [13:0]. Type 2'b01 gives `out_root` 1 with `out_index` = value.
- R4: Every pointer type other than 2'b01 gives `out_root` 0 with `out_index` = value.
- R5: One base entry serves the four codewords that share addr[31:22].
- R6: An offset-table row is 64 bits, and column c is the nibble in bits [4c+3:4c], with c = addr[19:16].
- R7: When `out_ready` stays high, one address is taken per cycle and its result appears three cycles later, in arrival order, with `out_tail` = addr[15:0].
- R8: While `out_valid` is high and `out_ready` is low, the result holds stable and `in_ready` is low.
- R9: A table write is ignored while any lookup is in the pipeline. `wr_sel` selects the table: 0 codeword, 1 base, 2 offset row (all 64 bits), 3 pointer. Tables 0, 1 and 3 take `wr_data[15:0]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Table write strobe |
| wr_sel | input | 2 | Table select |
| wr_addr | input | 12 | Table entry address |
| wr_data | input | 64 | Table entry data |
| in_valid | input | 1 | Address valid |
| in_ready | output | 1 | Address accepted this cycle |
| in_addr | input | 32 | Destination address |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Downstream accepts result |
| out_root | output | 1 | 1: chunk index, 0: next-hop index |
| out_index | output | 14 | Next-hop or chunk index |
| out_tail | output | 16 | Low address bits for the next level |

## Verification
The bench places the inline next hop in a codeword whose base and pointer slots hold decoys. A design that still walked the tables would return the decoy. Two codewords share one base, and two columns of one offset row are used. This catches slicing the base index at bit 20 instead of bit 22, and catches picking the wrong nibble. Both pointer types are decoded, including a non-root type other than zero. A back-to-back stream checks order and latency, and a design with a register too few or too many would shift every result by a cycle. A write issued while a result is held must leave the old table contents in place.

// File: rtl/prefix_l1_lookup.sv
module prefix_l1_lookup #(
  parameter int MAP_ROWS   = 676,
  parameter int PTR_DEPTH  = 1024,
  parameter logic [3:0] DIRECT_TAG = 4'b1111
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [1:0]  wr_sel,
  input  logic [11:0] wr_addr,
  input  logic [63:0] wr_data,
  input  logic        in_valid,
  output logic        in_ready,
  input  logic [31:0] in_addr,
  output logic        out_valid,
  input  logic        out_ready,
  output logic        out_root,
  output logic [13:0] out_index,
  output logic [15:0] out_tail
);
  localparam int PTR_AW = $clog2(PTR_DEPTH);
  localparam logic [9:0]  MAP_LIM = 10'(MAP_ROWS);
  localparam logic [16:0] PTR_LIM = 17'(PTR_DEPTH);

  logic [15:0] cw_mem   [0:4095];
  logic [15:0] base_mem [0:1023];
  logic [63:0] map_mem  [0:MAP_ROWS-1];
  logic [15:0] ptr_mem  [0:PTR_DEPTH-1];

  logic        s1_v, s2_v;
  logic [15:0] s1_cw, s1_base, s1_tail, s2_tail;
  logic [3:0]  s1_col;
  logic        s2_direct;
  logic [11:0] s2_hop;
  logic [15:0] s2_pix;

  wire busy  = s1_v | s2_v | out_valid;
  wire adv   = !out_valid || out_ready;
  wire wr_ok = wr_en && !busy;
  assign in_ready = adv && !wr_en;

  always_ff @(posedge clk) begin
    if (wr_ok) begin
      case (wr_sel)
        2'd0: cw_mem[wr_addr] <= wr_data[15:0];
        2'd1: base_mem[wr_addr[9:0]] <= wr_data[15:0];
        2'd2: if (wr_addr[9:0] < MAP_LIM) map_mem[wr_addr[9:0]] <= wr_data;
        default: if ({5'b0, wr_addr} < PTR_LIM) ptr_mem[wr_addr[PTR_AW-1:0]] <= wr_data[15:0];
      endcase
    end
  end

  // stage 1: codeword and base reads
  always_ff @(posedge clk) begin
    if (!rst_n) s1_v <= 1'b0;
    else if (adv) s1_v <= in_valid && in_ready;
  end

  always_ff @(posedge clk) begin
    if (adv) begin
      s1_cw   <= cw_mem[in_addr[31:20]];
      s1_base <= base_mem[in_addr[31:22]];
      s1_col  <= in_addr[19:16];
      s1_tail <= in_addr[15:0];
    end
  end

  // stage 2: offset-row read and pointer index sum
  wire [9:0]  ten    = s1_cw[15:6];
  wire [5:0]  six    = s1_cw[5:0];
  wire [63:0] row    = (ten < MAP_LIM) ? map_mem[ten] : 64'd0;
  wire [3:0]  nib    = row[{s1_col, 2'b00} +: 4];
  wire [15:0] pix    = s1_base + {10'd0, six} + {12'd0, nib};

  always_ff @(posedge clk) begin
    if (!rst_n) s2_v <= 1'b0;
    else if (adv) s2_v <= s1_v;
  end

  always_ff @(posedge clk) begin
    if (adv) begin
      s2_direct <= ten[9:6] == DIRECT_TAG;
      s2_hop    <= {ten[5:0], six};
      s2_pix    <= pix;
      s2_tail   <= s1_tail;
    end
  end

  // stage 3: pointer read and decode
  wire [15:0] ent = ({1'b0, s2_pix} < PTR_LIM) ? ptr_mem[s2_pix[PTR_AW-1:0]] : 16'd0;

  always_ff @(posedge clk) begin
    if (!rst_n) out_valid <= 1'b0;
    else if (adv) out_valid <= s2_v;
  end

  always_ff @(posedge clk) begin
    if (adv) begin
      out_root  <= !s2_direct && ent[15:14] == 2'b01;
      out_index <= s2_direct ? {2'b00, s2_hop} : ent[13:0];
      out_tail  <= s2_tail;
    end
  end

  AST_HOLD_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_index) && $stable(out_root) && $stable(out_tail)); // R8
  AST_STALL_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready); // R8
  AST_RESULT_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> $past(s2_v)); // R7
  AST_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && !s2_v |=> !out_valid); // R7
  AST_ACCEPT_ENTERS: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> s1_v); // R7
endmodule

// File: tb/test_prefix_l1_lookup.sv
module test_prefix_l1_lookup;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_sel = 2'd0;
  logic [11:0] wr_addr = 12'd0;
  logic [63:0] wr_data = 64'd0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_addr = 32'd0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic        out_root;
  logic [13:0] out_index;
  logic [15:0] out_tail;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  prefix_l1_lookup i_prefix_l1_lookup (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_addr(wr_addr),
    .wr_data(wr_data), .in_valid(in_valid), .in_ready(in_ready), .in_addr(in_addr),
    .out_valid(out_valid), .out_ready(out_ready), .out_root(out_root),
    .out_index(out_index), .out_tail(out_tail));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [11:0] a, input logic [63:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_addr = a; wr_data = d;
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  // single lookup; result three edges after acceptance
  task automatic look(input string req, input logic [31:0] a, input logic root, input logic [13:0] idx);
    @(negedge clk);
    in_valid = 1'b1; in_addr = a;
    @(posedge clk); #1;
    in_valid = 1'b0;
    @(posedge clk); @(negedge clk);
    check({req, " not yet valid"}, {31'd0, out_valid}, 32'd0);
    @(posedge clk); @(negedge clk);
    check({req, " valid"}, {31'd0, out_valid}, 32'd1);
    check({req, " root"}, {31'd0, out_root}, {31'd0, root});
    check({req, " index"}, {18'd0, out_index}, {18'd0, idx});
    check({req, " tail"}, {16'd0, out_tail}, {16'd0, a[15:0]});
  endtask

  task automatic t_reset;
    @(negedge clk);
    check("R1 out_valid", {31'd0, out_valid}, 32'd0);
    check("R1 in_ready", {31'd0, in_ready}, 32'd1);
  endtask

  task automatic t_load;
    wr(2'd0, 12'h0A0, {48'd0, 10'b1111_000101, 6'd9});
    wr(2'd1, 12'h028, 64'd3);
    wr(2'd3, 12'd12,  64'h4111);
    wr(2'd0, 12'h123, {48'd0, 10'd3, 6'd5});
    wr(2'd0, 12'h120, {48'd0, 10'd3, 6'd0});
    wr(2'd0, 12'h121, {48'd0, 10'd4, 6'd2});
    wr(2'd1, 12'h048, 64'd100);
    wr(2'd2, 12'd3, 64'hFEDCBA9876543210);
    wr(2'd2, 12'd4, 64'h1111111111111111);
    wr(2'd3, 12'd112, {48'd0, 2'b01, 14'h1ABC});
    wr(2'd3, 12'd107, {48'd0, 2'b00, 14'h0042});
    wr(2'd3, 12'd110, {48'd0, 2'b10, 14'h0100});
    wr(2'd3, 12'd100, {48'd0, 2'b01, 14'h0333});
    wr(2'd3, 12'd103, {48'd0, 2'b00, 14'h0777});
  endtask

  task automatic t_direct;
    look("R2 inline hop", 32'h0A05_1234, 1'b0, 14'd329);
  endtask

  task automatic t_pointer;
    look("R3 root chunk col7", 32'h1237_00AA, 1'b1, 14'h1ABC);
    look("R6 column 2", 32'h1232_0001, 1'b0, 14'h0042);
    look("R4 type 10 is hop", 32'h1235_FFFF, 1'b0, 14'h0100);
    look("R5 shared base cw120", 32'h1200_0000, 1'b1, 14'h0333);
    look("R5 shared base cw121", 32'h1219_0000, 1'b0, 14'h0777);
  endtask

  task automatic t_stream;
    logic [31:0] a [5];
    logic [14:0] e [5];
    a[0] = 32'h1237_0001; e[0] = {1'b1, 14'h1ABC};
    a[1] = 32'h0A00_0002; e[1] = {1'b0, 14'd329};
    a[2] = 32'h1232_0003; e[2] = {1'b0, 14'h0042};
    a[3] = 32'h1200_0004; e[3] = {1'b1, 14'h0333};
    a[4] = 32'h1219_0005; e[4] = {1'b0, 14'h0777};
    @(negedge clk);
    in_valid = 1'b1; in_addr = a[0];
    for (int i = 0; i < 7; i++) begin
      @(posedge clk); @(negedge clk);
      if (i >= 2) begin
        check("R7 stream valid", {31'd0, out_valid}, 32'd1);
        check("R7 stream result", {17'd0, out_root, out_index}, {17'd0, e[i-2]});
        check("R7 stream tail", {16'd0, out_tail}, {16'd0, a[i-2][15:0]});
      end
      if (i + 1 < 5) in_addr = a[i+1];
      else in_valid = 1'b0;
    end
    @(posedge clk); @(negedge clk);
    check("R7 stream drained", {31'd0, out_valid}, 32'd0);
  endtask

  task automatic t_backpressure;
    out_ready = 1'b0;
    @(negedge clk);
    in_valid = 1'b1; in_addr = 32'h1237_0000;
    @(posedge clk); #1;
    in_valid = 1'b0;
    repeat (5) @(posedge clk);
    @(negedge clk);
    check("R8 held valid", {31'd0, out_valid}, 32'd1);
    check("R8 in_ready low", {31'd0, in_ready}, 32'd0);
    check("R8 held index", {18'd0, out_index}, {18'd0, 14'h1ABC});
    wr(2'd0, 12'h0A0, {48'd0, 10'b1111_111111, 6'd63});
    @(negedge clk);
    out_ready = 1'b1;
    @(posedge clk); @(negedge clk);
    check("R8 released", {31'd0, out_valid}, 32'd0);
    look("R9 write while busy ignored", 32'h0A00_0000, 1'b0, 14'd329);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_load();
    t_direct();
    t_pointer();
    t_stream();
    t_backpressure();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual timeout expected completion");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule